// File: doc/BRIEF.md
# Synchronous Memory Bus Cycle Sequencer

This block is the master side of a clocked memory bus. A host asks for one transfer at a time by pulsing a start input together with an address, a direction flag and, for writes, a data word. The sequencer then runs a bus cycle. It pulls the active-low memory-request strobe low and places the address on the bus. For a read it also pulls the active-low read strobe low. For a write it drives the data word. When the cycle finishes it releases the strobes, hands the read data back and pulses done for one clock.

A transfer always lasts a whole number of clock periods. With no help from the slave it takes three clocks. A slave that needs more time holds its active-low wait line low. The sequencer samples that line at the edge that closes the second clock and at the edge that closes every inserted clock. Each low sample adds exactly one more clock before data is taken and the transfer completes. Data bus input and output are separate ports, and there is no tri-state.

Top module: `membus_seq`

## Requirements
- R1: While and after reset, bus_mreq_n and bus_rd_n are high, bus_dout_en, busy and rsp_done are low.
- R2: With bus_wait_n high throughout, bus_mreq_n is low for exactly three consecutive clock cycles, starting in the cycle after the edge that accepts req_start.
- R3: bus_addr equals the accepted req_addr in every cycle in which bus_mreq_n is low.
- R4: bus_rd_n is low in every cycle of a read transfer (req_write=0) in which bus_mreq_n is low, and stays high throughout a write transfer (req_write=1).
- R5: In every cycle of a write transfer, bus_dout_en is high and bus_dout equals the accepted req_wdata. bus_dout_en is low in all other cycles.
- R6: bus_wait_n is sampled at the rising edge that closes the second transfer cycle and at the edge that closes each inserted cycle. Every low sample adds one cycle, so N low samples give a window of 3+N cycles.
- R7: rsp_done is high for exactly one cycle, the cycle right after the last bus_mreq_n-low cycle. For a read, rsp_rdata then equals the bus_din value present in the last cycle of the window. A write leaves rsp_rdata unchanged.
- R8: busy is high in every cycle of the bus_mreq_n-low window and low in the rsp_done cycle. A req_start asserted while busy is ignored: address, direction and length of the running transfer are unchanged, and no extra transfer follows.
- R9: A req_start asserted in the rsp_done cycle is accepted. The next transfer's bus_mreq_n-low window begins in the following cycle.
- R10: The level of bus_wait_n during the first transfer cycle has no effect on the transfer length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start pulse, accepted only when idle |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Data captured by the most recent read |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| bus_addr | output | AW | Address lines |
| bus_dout | output | DW | Data driven to the slave |
| bus_dout_en | output | 1 | High while write data is driven |
| bus_din | input | DW | Data returned by the slave |
| bus_mreq_n | output | 1 | Active-low memory-request strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wait_n | input | 1 | Active-low wait request from the slave |

## Verification
Completion of one transfer and acceptance of the next can fall in the same cycle. The rsp_done cycle is also the first idle cycle, so a start seen there must open a new window one clock later. The bench raises req_start exactly in the observed rsp_done cycle. It then checks that the very next cycle already shows the new address, the new direction and a low request strobe. The opposite clash, a start arriving in the middle of a window, is provoked while wait states are being inserted. It is judged by an unchanged address, an unchanged window length and a quiet bus after the done pulse.

// File: rtl/membus_pkg.sv
// Shared types for the memory bus sequencer.
// Assumes a single clock domain; the state encoding is private to the block.
package membus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no transfer
        ST_ADDR = 3'd1,  // first cycle: address placed
        ST_DATA = 3'd2,  // second cycle: wait sampled at its closing edge
        ST_WAIT = 3'd3,  // inserted whole cycle
        ST_LAST = 3'd4   // final cycle: read data captured at its closing edge
    } bus_state_t;
endpackage

// File: rtl/membus_fsm.sv
// Cycle sequencer: steps through the fixed three-cycle frame and stretches
// it by one whole cycle for each low sample of the wait line.
// Assumes wait_n is synchronous to clk. Starts are accepted only when idle.
module membus_fsm
    import membus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wait_n,
    output bus_state_t state,
    output logic       accept,
    output logic       done
);
    bus_state_t state_nx;

    // Acceptance of a new request: only from the idle state
    always_comb accept = start && (state == ST_IDLE);

    // Next-state selection; wait is looked at only when leaving DATA or WAIT
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start) state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA: state_nx = wait_n ? ST_LAST : ST_WAIT;
            ST_WAIT: state_nx = wait_n ? ST_LAST : ST_WAIT;
            ST_LAST: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // One-cycle completion pulse in the cycle after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_LAST);
    end
endmodule

// File: rtl/membus_datapath.sv
// Request holding and read capture: latches the request on acceptance and
// samples the slave's data at the edge that closes the last cycle of a read.
// Assumes accept and capture never coincide.
module membus_datapath #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_din,
    output logic          wr_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    // Hold the request fields for the length of the transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the read data at the end of the final cycle of a read
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (capture && !wr_q) rdata_q <= bus_din;
    end
endmodule

// File: rtl/membus_strobes.sv
// Strobe decode: derives the active-low request/read strobes and the write
// drive enable from the registered state and direction, so the outputs do not
// depend on any input combinationally.
module membus_strobes
    import membus_pkg::*;
(
    input  bus_state_t state,
    input  logic       wr_q,
    output logic       mreq_n,
    output logic       rd_n,
    output logic       dout_en,
    output logic       busy
);
    logic active;

    // Decode of the transfer window and the per-direction strobes
    always_comb begin
        active  = (state != ST_IDLE);
        busy    = active;
        mreq_n  = !active;
        rd_n    = !(active && !wr_q);
        dout_en = active && wr_q;
    end
endmodule

// File: rtl/membus_seq.sv
// Synchronous memory bus master. Runs one read or write per start pulse in a
// three-cycle frame that is stretched by whole wait cycles.
// Assumes one clock, synchronous active-low reset, separate data in/out lines.
module membus_seq
    import membus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          busy,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    output logic          bus_mreq_n,
    output logic          bus_rd_n,
    input  logic          bus_wait_n
);
    bus_state_t state;
    logic       accept;
    logic       wr_q;
    logic       capture;

    // Data is taken while the final cycle is active
    always_comb capture = (state == ST_LAST);

    membus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_start),
        .wait_n (bus_wait_n),
        .state  (state),
        .accept (accept),
        .done   (rsp_done)
    );

    membus_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_din   (bus_din),
        .wr_q      (wr_q),
        .addr_q    (bus_addr),
        .wdata_q   (bus_dout),
        .rdata_q   (rsp_rdata)
    );

    membus_strobes u_stb (
        .state   (state),
        .wr_q    (wr_q),
        .mreq_n  (bus_mreq_n),
        .rd_n    (bus_rd_n),
        .dout_en (bus_dout_en),
        .busy    (busy)
    );
endmodule

// File: rtl/membus_seq_chk.sv
// Protocol checker for membus_seq, attached by bind. Observes ports only.
module membus_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rsp_done,
    input logic          busy,
    input logic [AW-1:0] bus_addr,
    input logic          bus_dout_en,
    input logic          bus_mreq_n,
    input logic          bus_rd_n
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (bus_mreq_n && bus_rd_n && !busy && !rsp_done));

    // R2
    min_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_mreq_n) |=> !bus_mreq_n);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!bus_mreq_n && $past(!bus_mreq_n)) |-> $stable(bus_addr));

    // R4
    write_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_dout_en |-> bus_rd_n);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);

    // R7
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rsp_done) |-> $past(!bus_mreq_n));

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> (!busy && bus_mreq_n));
endmodule

bind membus_seq membus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_done    (rsp_done),
    .busy        (busy),
    .bus_addr    (bus_addr),
    .bus_dout_en (bus_dout_en),
    .bus_mreq_n  (bus_mreq_n),
    .bus_rd_n    (bus_rd_n)
);

// File: tb/tb_membus_seq.sv
module tb_membus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    // wr, addr, wdata, din, nwait, mode (0 plain, 1 wait low in first cycle, 2 start while busy)
    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] din;
        logic [3:0]  nw;
        logic [1:0]  mode;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 16'h0000, 16'hBEEF, 4'd0, 2'd0},
        '{1'b1, 16'h0040, 16'hA5A5, 16'h0000, 4'd0, 2'd0},
        '{1'b0, 16'h00FF, 16'h0000, 16'h1357, 4'd1, 2'd0},
        '{1'b1, 16'h8001, 16'h3C3C, 16'h0000, 4'd3, 2'd0},
        '{1'b0, 16'h7FFE, 16'h0000, 16'h0F0F, 4'd5, 2'd1},
        '{1'b1, 16'h1111, 16'hFFFF, 16'h0000, 4'd2, 2'd2},
        '{1'b0, 16'hFFFF, 16'h0000, 16'h0000, 4'd0, 2'd2},
        '{1'b0, 16'h0000, 16'h0000, 16'hFFFF, 4'd2, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic          busy;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_en;
    logic [DW-1:0] bus_din = '0;
    logic          bus_mreq_n;
    logic          bus_rd_n;
    logic          bus_wait_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] last_rd = '0;
    bit finished = 0;

    membus_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .busy(busy), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_mreq_n(bus_mreq_n),
        .bus_rd_n(bus_rd_n), .bus_wait_n(bus_wait_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Start a transfer at a negedge; returns at the negedge of the first window cycle
    task automatic launch(input logic wr, input logic [15:0] a, input logic [15:0] wd);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    // Walk the window from its first cycle; drive wait/din per cycle and check ports
    task automatic walk(input vec_t v);
        int c = 0;
        while (!bus_mreq_n && c < 40) begin
            req_start = 1'b0;
            req_addr = v.addr; req_write = v.wr;
            chk(bus_addr == v.addr, "R3", 32'(bus_addr), 32'(v.addr));
            chk(bus_rd_n == v.wr, "R4", 32'(bus_rd_n), 32'(v.wr));
            chk(bus_dout_en == v.wr, "R5", 32'(bus_dout_en), 32'(v.wr));
            if (v.wr) chk(bus_dout == v.wdata, "R5", 32'(bus_dout), 32'(v.wdata));
            chk(busy && !rsp_done, "R8", {30'd0, busy, rsp_done}, 32'h2);
            if (c == 0) bus_wait_n = (v.mode == 2'd1) ? 1'b0 : 1'b1;
            else        bus_wait_n = (c <= int'(v.nw)) ? 1'b0 : 1'b1;
            bus_din = (c == int'(v.nw) + 2) ? v.din : ~v.din;
            if (v.mode == 2'd2 && c == 1) begin
                req_start = 1'b1; req_addr = ~v.addr; req_write = ~v.wr;
            end
            @(negedge clk);
            c++;
        end
        bus_wait_n = 1'b1;
        req_start = 1'b0;
        if (v.mode == 2'd1) chk(c == int'(v.nw) + 3, "R10", 32'(c), 32'(v.nw) + 3);
        else if (v.nw == 0) chk(c == 3, "R2", 32'(c), 32'd3);
        else chk(c == int'(v.nw) + 3, "R6", 32'(c), 32'(v.nw) + 3);
        if (!v.wr) last_rd = v.din;
        chk(rsp_done == 1'b1, "R7", 32'(rsp_done), 32'd1);
        chk(rsp_rdata == last_rd, "R7", 32'(rsp_rdata), 32'(last_rd));
        chk(busy == 1'b0, "R8", 32'(busy), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(bus_mreq_n && bus_rd_n && !bus_dout_en && !busy && !rsp_done, "R1",
            {27'd0, bus_mreq_n, bus_rd_n, bus_dout_en, busy, rsp_done}, 32'h18);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_mreq_n && !busy, "R1", {30'd0, bus_mreq_n, busy}, 32'h2);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            walk(VECS[i]);
            @(negedge clk);
            // R7/R8: done lasts one cycle and no stray transfer follows
            chk(!rsp_done && bus_mreq_n, "R8", {30'd0, rsp_done, bus_mreq_n}, 32'h1);
            chk(rsp_rdata == last_rd, "R7", 32'(rsp_rdata), 32'(last_rd));
        end

        // R9: start accepted in the done cycle
        launch(1'b0, 16'h2468, 16'h0);
        walk('{1'b0, 16'h2468, 16'h0000, 16'h55AA, 4'd0, 2'd0});
        launch(1'b1, 16'h9ABC, 16'hC0DE);
        chk(!bus_mreq_n && bus_addr == 16'h9ABC && bus_dout_en, "R9",
            {15'd0, bus_mreq_n, bus_addr}, {16'h0000, 16'h9ABC});
        walk('{1'b1, 16'h9ABC, 16'hC0DE, 16'h0000, 4'd1, 2'd0});
        @(negedge clk);

        // R1: reset in the middle of a transfer returns the strobes high
        launch(1'b0, 16'h0F00, 16'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bus_mreq_n && bus_rd_n && !busy && !rsp_done, "R1",
            {28'd0, bus_mreq_n, bus_rd_n, busy, rsp_done}, 32'hC);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule